// File: doc/BRIEF.md
# Oversampling Serial Receiver with Idle-Line Flag

This block turns an idle-high asynchronous serial line into parallel characters. A divider derives a sample tick at sixteen times the bit rate. The line passes through a two-stage synchronizer, and a falling edge starts a frame. The frame is kept only if the start bit still reads low at its centre. Every later bit is sampled at its own centre, one bit time after the one before.

The character length (5 to 8 bits) and the parity mode are runtime inputs. A finished character goes into a holding register, right-aligned, and a not-empty flag is raised with it. Parity and stop-bit faults are flagged next to that character. A character that arrives while the register is still full is discarded and flagged as an overrun.

An idle flag marks the end of a burst. It rises after the line has stayed high for one full frame time following received data. A single read pulse consumes the character and clears every status flag.

Top module: `uart_rx_idle`

## Requirements
- R1: A start is taken only on a falling edge of the synchronized line. The line is sampled again 8 ticks later, and if it is high the frame is dropped without touching any output.
- R2: Each bit lasts 16 ticks of CLKS_PER_TICK clocks and is sampled at its centre. Bits are received LSB first. cfg_len_i codes 0,1,2,3 select 5,6,7,8 data bits, and the character is right-aligned in rx_data_o with the unused upper bits zero.
- R3: cfg_par_i codes are 0 none, 1 even, 2 odd, 3 space (bit must be 0), 4 mark (bit must be 1); codes 5 to 7 mean none. Codes 1 to 4 add one parity bit after the data. A mismatch sets par_err_o together with the stored character.
- R4: The first stop bit is sampled at its centre. If it reads low, frm_err_o is set and the character is still stored.
- R5: When a character completes and the register is empty, rx_data_o takes the character and not_empty_o goes to 1.
- R6: When a character completes while not_empty_o is 1 and no read is present, overrun_o is set. The new character is dropped, and rx_data_o, par_err_o and frm_err_o keep their values.
- R7: A one-cycle rd_i pulse clears not_empty_o, par_err_o, frm_err_o, overrun_o and idle_o on the next clock.
- R8: After a character, idle_o is set once the line has been high with no frame in progress for 16*(2+data bits+parity bits) ticks. It fires only once per burst and rearms only after another character is received.
- R9: After reset all flags are 0 and rx_data_o is 0.
- R10: The receiver rearms at the centre of the stop bit, so a start edge that follows straight after the stop bit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial line, idle high |
| cfg_len_i | input | 2 | Data length code (0..3 gives 5..8 bits) |
| cfg_par_i | input | 3 | Parity mode code |
| rd_i | input | 1 | Read pulse: consumes the character and clears status |
| rx_data_o | output | 8 | Received character, right-aligned |
| not_empty_o | output | 1 | Holding register is full |
| par_err_o | output | 1 | Parity mismatch on the held character |
| frm_err_o | output | 1 | Stop bit read low on the held character |
| overrun_o | output | 1 | A character was lost because the register was full |
| idle_o | output | 1 | Line went idle after a burst |

## Verification
A table of frames covers every length code and every parity mode, each sent with correct and with corrupted parity, plus frames with a low stop bit. This shows whether right-alignment, the parity rule for each mode, and stop sampling are each right. Frames are sent back to back, so rearming at mid-stop is exercised as well. Directed cases send short low glitches, which must be rejected, and two characters with no read between them, which must produce an overrun that keeps the first. The idle flag is checked for its timing both before and after one frame time, for firing only once, and for rearming after a new character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    localparam logic [2:0] PAR_NONE  = 3'd0;
    localparam logic [2:0] PAR_EVEN  = 3'd1;
    localparam logic [2:0] PAR_ODD   = 3'd2;
    localparam logic [2:0] PAR_SPACE = 3'd3;
    localparam logic [2:0] PAR_MARK  = 3'd4;

    function automatic logic [3:0] data_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic par_used(input logic [2:0] mode);
        return (mode >= PAR_EVEN) && (mode <= PAR_MARK);
    endfunction

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int CLKS_PER_TICK = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (CLKS_PER_TICK <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(CLKS_PER_TICK);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                if (cnt_q == CW'(CLKS_PER_TICK - 1)) cnt_d = '0;
                else                                 cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == CW'(CLKS_PER_TICK - 1));

            // R2: ticks are single-cycle pulses
            p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic dout_o,
    output logic fall_o
);
    logic [STAGES-1:0] sr_d, sr_q;
    logic              prev_d, prev_q;

    always_comb begin
        sr_d   = {sr_q[STAGES-2:0], din_i};
        prev_d = sr_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '1;
            prev_q <= 1'b1;
        end else begin
            sr_q   <= sr_d;
            prev_q <= prev_d;
        end
    end

    assign dout_o = sr_q[STAGES-1];
    assign fall_o = prev_q & ~sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       rx_i,
    input  logic       fall_i,
    input  logic [1:0] cfg_len_i,
    input  logic [2:0] cfg_par_i,
    input  logic       rd_i,
    output logic [7:0] data_o,
    output logic       nempty_o,
    output logic       perr_o,
    output logic       ferr_o,
    output logic       ovr_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam int CW   = $clog2(OSR);
    localparam int HALF = OSR / 2;

    typedef struct packed {
        rx_state_e  st;
        logic [CW-1:0] cnt;
        logic [3:0] idx;
        logic [7:0] sh;
        logic       pbit;
        logic [7:0] data;
        logic       nempty;
        logic       perr;
        logic       ferr;
        logic       ovr;
    } frm_t;

    frm_t       q, d;
    logic       done;
    logic [3:0] nbits;
    logic [7:0] aligned;
    logic       ones;
    logic       bad_par;
    logic       mid;

    always_comb begin
        d       = q;
        done    = 1'b0;
        nbits   = data_bits(cfg_len_i);
        aligned = q.sh >> (4'd8 - nbits);
        ones    = ^aligned;
        mid     = tick_i && (q.cnt == CW'(OSR - 1));
        case (cfg_par_i)
            PAR_EVEN:  bad_par = ones ^ q.pbit;
            PAR_ODD:   bad_par = ~(ones ^ q.pbit);
            PAR_SPACE: bad_par = q.pbit;
            PAR_MARK:  bad_par = ~q.pbit;
            default:   bad_par = 1'b0;
        endcase

        if (rd_i) begin
            d.nempty = 1'b0;
            d.perr   = 1'b0;
            d.ferr   = 1'b0;
            d.ovr    = 1'b0;
        end

        if (tick_i && q.st != ST_IDLE) d.cnt = q.cnt + 1'b1;

        case (q.st)
            ST_IDLE: begin
                if (fall_i) begin
                    d.st  = ST_START;
                    d.cnt = '0;
                end
            end
            ST_START: begin
                if (tick_i && q.cnt == CW'(HALF - 1)) begin
                    d.cnt = '0;
                    d.idx = '0;
                    d.st  = rx_i ? ST_IDLE : ST_DATA;
                end
            end
            ST_DATA: begin
                if (mid) begin
                    d.sh = {rx_i, q.sh[7:1]};
                    if (q.idx == nbits - 4'd1)
                        d.st = par_used(cfg_par_i) ? ST_PAR : ST_STOP;
                    else
                        d.idx = q.idx + 4'd1;
                end
            end
            ST_PAR: begin
                if (mid) begin
                    d.pbit = rx_i;
                    d.st   = ST_STOP;
                end
            end
            ST_STOP: begin
                if (mid) begin
                    done = 1'b1;
                    d.st = ST_IDLE;
                    if (q.nempty && !rd_i) begin
                        d.ovr = 1'b1;
                    end else begin
                        d.data   = aligned;
                        d.nempty = 1'b1;
                        d.perr   = bad_par;
                        d.ferr   = ~rx_i;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign data_o   = q.data;
    assign nempty_o = q.nempty;
    assign perr_o   = q.perr;
    assign ferr_o   = q.ferr;
    assign ovr_o    = q.ovr;
    assign busy_o   = (q.st != ST_IDLE);
    assign done_o   = done;

    // R7: a read with no completing character empties the register
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !done) |=> (!q.nempty && !q.perr && !q.ferr && !q.ovr));
    // R6: a full register keeps its character when another completes
    p_overrun_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.nempty && !rd_i) |=> (q.ovr && $stable(q.data)));
    // R5: the not-empty flag rises only with a completed frame
    p_fill_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.nempty) |-> $past(done));
    // R4: a framing error always goes with a held character
    p_ferr_with_char_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.ferr |-> q.nempty);
endmodule

// File: rtl/uart_rx_idle_det.sv
module uart_rx_idle_det
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       rx_i,
    input  logic       busy_i,
    input  logic       done_i,
    input  logic       rd_i,
    input  logic [1:0] cfg_len_i,
    input  logic [2:0] cfg_par_i,
    output logic       idle_o
);
    localparam int MAXT = OSR * 12;
    localparam int TW   = $clog2(MAXT) + 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          armed;
        logic          flag;
    } idl_t;

    idl_t          q, d;
    logic [TW-1:0] frame_ticks;

    always_comb begin
        d           = q;
        frame_ticks = TW'(OSR) * TW'(4'd2 + data_bits(cfg_len_i)
                                    + {3'b000, par_used(cfg_par_i)});
        if (rd_i) d.flag = 1'b0;
        if (done_i) begin
            d.armed = 1'b1;
            d.cnt   = '0;
        end else if (busy_i || !rx_i) begin
            d.cnt = '0;
        end else if (q.armed && tick_i) begin
            if (q.cnt == frame_ticks - 1'b1) begin
                d.flag  = 1'b1;
                d.armed = 1'b0;
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idle_o = q.flag;

    // R8: the idle flag is raised only from a high, quiet line
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flag) |-> ($past(rx_i) && !$past(busy_i)));
    // R8: the idle flag is raised only after a character has armed it
    p_idle_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flag) |-> $past(q.armed));
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
    parameter int CLKS_PER_TICK = 2,
    parameter int OSR           = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd_i,
    input  logic [1:0] cfg_len_i,
    input  logic [2:0] cfg_par_i,
    input  logic       rd_i,
    output logic [7:0] rx_data_o,
    output logic       not_empty_o,
    output logic       par_err_o,
    output logic       frm_err_o,
    output logic       overrun_o,
    output logic       idle_o
);
    logic tick, rx_s, fall, busy, done;

    uart_rx_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din_i(rxd_i), .dout_o(rx_s), .fall_o(fall)
    );

    uart_rx_frame #(.OSR(OSR)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_s), .fall_i(fall),
        .cfg_len_i(cfg_len_i), .cfg_par_i(cfg_par_i), .rd_i(rd_i),
        .data_o(rx_data_o), .nempty_o(not_empty_o), .perr_o(par_err_o),
        .ferr_o(frm_err_o), .ovr_o(overrun_o), .busy_o(busy), .done_o(done)
    );

    uart_rx_idle_det #(.OSR(OSR)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_s), .busy_i(busy),
        .done_i(done), .rd_i(rd_i), .cfg_len_i(cfg_len_i),
        .cfg_par_i(cfg_par_i), .idle_o(idle_o)
    );
endmodule

// File: tb/uart_rx_idle_test.sv
`timescale 1ns/1ps
module uart_rx_idle_test;
    localparam int CPT = 2;
    localparam int BIT = 16 * CPT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [2:0] cfg_par = 3'd0;
    logic       rd = 1'b0;
    logic [7:0] rx_data;
    logic       nempty, perr, ferr, ovr, idle;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    uart_rx_idle #(.CLKS_PER_TICK(CPT)) uut (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .cfg_len_i(cfg_len),
        .cfg_par_i(cfg_par), .rd_i(rd), .rx_data_o(rx_data),
        .not_empty_o(nempty), .par_err_o(perr), .frm_err_o(ferr),
        .overrun_o(ovr), .idle_o(idle)
    );

    typedef struct packed {
        logic [1:0] len;
        logic [2:0] par;
        logic [7:0] val;
        logic       bad_par;
        logic       bad_stop;
        logic [7:0] exp_data;
        logic       exp_pe;
        logic       exp_fe;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 3'd0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
        '{2'd3, 3'd1, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
        '{2'd3, 3'd2, 8'h81, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0},
        '{2'd0, 3'd0, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
        '{2'd1, 3'd1, 8'h2A, 1'b1, 1'b0, 8'h2A, 1'b1, 1'b0},
        '{2'd2, 3'd2, 8'h7F, 1'b1, 1'b0, 8'h7F, 1'b1, 1'b0},
        '{2'd3, 3'd3, 8'h55, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0},
        '{2'd3, 3'd4, 8'h55, 1'b1, 1'b0, 8'h55, 1'b1, 1'b0},
        '{2'd3, 3'd3, 8'hC3, 1'b1, 1'b0, 8'hC3, 1'b1, 1'b0},
        '{2'd2, 3'd4, 8'hE3, 1'b0, 1'b0, 8'h63, 1'b0, 1'b0},
        '{2'd3, 3'd0, 8'h0F, 1'b0, 1'b1, 8'h0F, 1'b0, 1'b1},
        '{2'd0, 3'd1, 8'h13, 1'b0, 1'b1, 8'h13, 1'b0, 1'b1},
        '{2'd3, 3'd4, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int clocks);
        @(negedge clk);
        rxd = v;
        repeat (clocks - 1) @(negedge clk);
    endtask

    task automatic send(input logic [1:0] len, input logic [2:0] par,
                        input logic [7:0] val, input logic bp, input logic bs);
        int   n = 5 + int'(len);
        logic ones = 1'b0;
        logic p;
        cfg_len = len;
        cfg_par = par;
        hold(1'b0, BIT);
        for (int i = 0; i < n; i++) begin
            ones ^= val[i];
            hold(val[i], BIT);
        end
        case (par)
            3'd1: p = ones;
            3'd2: p = ~ones;
            3'd3: p = 1'b0;
            default: p = 1'b1;
        endcase
        if (par >= 3'd1 && par <= 3'd4) hold(p ^ bp, BIT);
        hold(~bs, BIT);
        @(negedge clk);
        rxd = 1'b1;
    endtask

    task automatic read_pulse;
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_clks(3);
        // R9: reset state
        chk("R9 nempty", {7'b0, nempty}, 8'h00);
        chk("R9 data", rx_data, 8'h00);
        chk("R9 flags", {4'b0, perr, ferr, ovr, idle}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        wait_clks(5);

        // R1: glitches shorter than half a bit are rejected
        hold(1'b0, 6);
        hold(1'b1, 3 * BIT);
        hold(1'b0, 12);
        hold(1'b1, 20 * BIT);
        chk("R1 glitch nempty", {7'b0, nempty}, 8'h00);
        chk("R1 glitch flags", {4'b0, perr, ferr, ovr, idle}, 8'h00);

        // R2 R3 R4 R5 R7 R10: vector table, frames back to back
        for (int k = 0; k < NV; k++) begin
            send(VECS[k].len, VECS[k].par, VECS[k].val,
                 VECS[k].bad_par, VECS[k].bad_stop);
            chk("R5 nempty", {7'b0, nempty}, 8'h01);
            chk("R2 data", rx_data, VECS[k].exp_data);
            chk("R3 parity err", {7'b0, perr}, {7'b0, VECS[k].exp_pe});
            chk("R4 framing err", {7'b0, ferr}, {7'b0, VECS[k].exp_fe});
            chk("R10 no overrun", {7'b0, ovr}, 8'h00);
            read_pulse();
            chk("R7 cleared", {6'b0, nempty, perr | ferr}, 8'h00);
        end

        // R8: idle timing after the last frame (8 data + parity = 11 bits)
        wait_clks(8 * BIT);
        chk("R8 idle not yet", {7'b0, idle}, 8'h00);
        wait_clks(7 * BIT);
        chk("R8 idle set", {7'b0, idle}, 8'h01);
        read_pulse();
        chk("R7 idle cleared", {7'b0, idle}, 8'h00);
        wait_clks(20 * BIT);
        chk("R8 fires once", {7'b0, idle}, 8'h00);

        // R6: overrun keeps the first character
        send(2'd3, 3'd0, 8'h11, 1'b0, 1'b0);
        send(2'd3, 3'd0, 8'h22, 1'b1, 1'b1);
        chk("R6 overrun set", {7'b0, ovr}, 8'h01);
        chk("R6 data kept", rx_data, 8'h11);
        chk("R6 flags kept", {6'b0, perr, ferr}, 8'h00);
        chk("R6 still full", {7'b0, nempty}, 8'h01);

        // R8: rearmed by the new burst
        wait_clks(15 * BIT);
        chk("R8 idle rearmed", {7'b0, idle}, 8'h01);
        read_pulse();
        chk("R7 overrun cleared", {6'b0, ovr, idle}, 8'h00);
        chk("R7 nempty cleared", {7'b0, nempty}, 8'h00);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule